// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer for an 8-bit CPU

This block runs the external bus for a small 8-bit processor core. Each instruction starts with an opcode fetch: the program counter is driven onto the address bus, the memory returns the opcode on the data bus, and the byte is latched into the instruction register. One decode/execute clock follows. During that clock an external decoder looks at the latched opcode and reports the instruction length and the kind of data access it needs. The sequencer then reads any operand bytes from the following program addresses. If the instruction calls for it, one memory read or one memory write follows, at the address formed by the operand bytes. After that, the next opcode fetch begins.

Every bus cycle uses the same three-state pattern. In the first state only the address is driven. A strobe is added in the second and third states. A slow memory holds the ready input low to stretch the cycle with wait states, and the sequencer keeps the whole bus frozen while it waits. The arithmetic unit and the full instruction decoder sit outside this block.

Top module: `mseq_top`

## Requirements
- R1: While reset is low, and on the first clock after it is released, the sequencer is in the first state of an opcode fetch at address 0: addr_o = 0, fetch_o = 1, rd_o = 0, wr_o = 0, exec_o = 0.
- R2: A bus cycle without waits takes three clocks. In the first, addr_o is valid and both strobes are low. In the second and third, the strobe is high and addr_o does not change. Read-type cycles (opcode, operand, data read) assert rd_o. Write cycles assert wr_o.
- R3: ready_i is sampled only at the end of the second state and at the end of each wait state. While it is low, a wait state is inserted, and addr_o, rd_o, wr_o and data_o hold their values. When it is high, the third state follows.
- R4: At the end of the third state of an opcode fetch, data_i is loaded into ir_o. The next clock is a single decode/execute clock with exec_o = 1 and both strobes low.
- R5: The program counter advances by exactly one after each opcode byte and each operand byte. Data read and data write cycles leave it unchanged.
- R6: len_i is sampled during the decode clock. A value of 0 or 1 means a one-byte instruction, 2 means one operand byte and 3 means two operand bytes. Operand cycles read successive program addresses with fetch_o = 0. The first operand byte goes to opr_o[7:0] and the second to opr_o[15:8], and the fetch of an opcode clears opr_o to zero.
- R7: When acc_i = 2'b01 during the decode clock, a data read cycle at address opr_o follows the operand cycles. Its byte is loaded into rdata_o at the end of the third state.
- R8: When acc_i = 2'b10 during the decode clock, a write cycle at address opr_o follows the operand cycles. Throughout its strobe, data_o holds the wdata_i value sampled during the decode clock.
- R9: When acc_i is 2'b00 or 2'b11, no data access takes place, and the next opcode fetch starts right after the last operand cycle, or right after the decode clock if there are no operands.
- R10: rd_o and wr_o are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_o | output | 16 | Bus address |
| data_i | input | 8 | Read data from memory |
| data_o | output | 8 | Write data to memory |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| ready_i | input | 1 | Memory ready; low requests a wait state |
| len_i | input | 2 | Instruction length code from decoder |
| acc_i | input | 2 | Data access code from decoder (01 read, 10 write) |
| wdata_i | input | 8 | Store data, sampled in the decode clock |
| ir_o | output | 8 | Instruction register |
| opr_o | output | 16 | Collected operand bytes |
| rdata_o | output | 8 | Byte returned by the last data read cycle |
| fetch_o | output | 1 | High during an opcode fetch cycle |
| exec_o | output | 1 | High in the decode/execute clock |

## Verification
The assertions check on every clock the properties that concern the state of the bus alone. They confirm that the strobes are never both high, that the bus stays frozen and a wait state is entered while ready is low, that the third state follows once ready is high, that the execute clock lasts one cycle and follows a fetch, and that the program counter only ever holds or steps by one. Other behaviours can only be shown by the bench's scenarios, which model the memory and the decoder: which address and strobe appear in each machine cycle, how many operand and data cycles a given opcode produces, which byte lands in each register, the write data, a read that follows a write to the same location, and a reset in the middle of a run.

// File: rtl/mseq_pkg.sv
// Package: shared types and helpers for the machine-cycle bus sequencer.
// Assumes at most two operand bytes per instruction.
package mseq_pkg;

    localparam int OPR_BYTES = 2;
    localparam int IDX_W     = (OPR_BYTES > 1) ? $clog2(OPR_BYTES) : 1;

    // Bus states within a machine cycle, plus the decode/execute clock.
    typedef enum logic [2:0] {
        TS_T1 = 3'd0,
        TS_T2 = 3'd1,
        TS_TW = 3'd2,
        TS_T3 = 3'd3,
        TS_TD = 3'd4
    } tstate_e;

    // Kind of machine cycle being run.
    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,
        MC_OPR   = 2'd1,
        MC_MRD   = 2'd2,
        MC_MWR   = 2'd3
    } mcyc_e;

    localparam logic [1:0] ACC_RD = 2'b01;
    localparam logic [1:0] ACC_WR = 2'b10;

    // Number of operand bytes implied by a length code.
    function automatic logic [1:0] ops_for_len(input logic [1:0] len);
        case (len)
            2'd2:    return 2'd1;
            2'd3:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // Next machine cycle once the remaining operand count is known.
    function automatic mcyc_e next_kind(input logic [1:0] rem, input logic [1:0] acc);
        if (rem != 2'd0)      return MC_OPR;
        else if (acc == ACC_RD) return MC_MRD;
        else if (acc == ACC_WR) return MC_MWR;
        else                  return MC_FETCH;
    endfunction

endpackage

// File: rtl/mseq_tstate.sv
// Module: T-state timer. Steps T1 -> T2 -> (TW*) -> T3, then either the
// decode clock or the next T1. Assumes ready_i is synchronous to clk.
module mseq_tstate
    import mseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ready_i,
    input  logic    dec_after_i,
    output tstate_e t_o
);

    // Advance the bus state; waits repeat while ready is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_o <= TS_T1;
        end else begin
            case (t_o)
                TS_T1:        t_o <= TS_T2;
                TS_T2, TS_TW: t_o <= ready_i ? TS_T3 : TS_TW;
                TS_T3:        t_o <= dec_after_i ? TS_TD : TS_T1;
                TS_TD:        t_o <= TS_T1;
                default:      t_o <= TS_T1;
            endcase
        end
    end

endmodule

// File: rtl/mseq_ctrl.sv
// Module: machine-cycle controller. Picks which kind of bus cycle runs next,
// counts the remaining operand bytes and remembers the pending data access.
// Assumes len_i/acc_i are valid during the decode clock.
module mseq_ctrl
    import mseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tstate_e          t_i,
    input  logic [1:0]       len_i,
    input  logic [1:0]       acc_i,
    output mcyc_e            kind_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [1:0] rem_q;
    logic [1:0] acc_q;
    logic [1:0] ops_now;
    logic [1:0] rem_dec;

    assign ops_now = ops_for_len(len_i);
    assign rem_dec = rem_q - 2'd1;

    // Update cycle kind at the end of the decode clock and of each T3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_o <= MC_FETCH;
            rem_q  <= 2'd0;
            acc_q  <= 2'd0;
            idx_o  <= '0;
        end else if (t_i == TS_TD) begin
            rem_q  <= ops_now;
            acc_q  <= acc_i;
            kind_o <= next_kind(ops_now, acc_i);
            idx_o  <= '0;
        end else if (t_i == TS_T3) begin
            case (kind_o)
                MC_OPR: begin
                    rem_q  <= rem_dec;
                    idx_o  <= idx_o + 1'b1;
                    kind_o <= next_kind(rem_dec, acc_q);
                end
                MC_MRD, MC_MWR: kind_o <= MC_FETCH;
                default:        kind_o <= kind_o;
            endcase
        end
    end

endmodule

// File: rtl/mseq_datapath.sv
// Module: program counter, instruction register, operand lanes, read and
// write data registers, and the address multiplexer. Assumes state and
// cycle kind come from the timer and controller.
module mseq_datapath
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  tstate_e                     t_i,
    input  mcyc_e                       kind_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [DATA_W-1:0]           data_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [ADDR_W-1:0]           addr_o,
    output logic [ADDR_W-1:0]           pc_o,
    output logic [DATA_W-1:0]           ir_o,
    output logic [OPR_BYTES*DATA_W-1:0] opr_o,
    output logic [DATA_W-1:0]           rdata_o,
    output logic [DATA_W-1:0]           data_o
);

    localparam int OPR_W = OPR_BYTES * DATA_W;

    logic              end_t3;
    logic              end_td;
    logic [ADDR_W-1:0] data_addr;

    assign end_t3 = (t_i == TS_T3);
    assign end_td = (t_i == TS_TD);

    // Program counter: steps after each opcode or operand byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_o <= '0;
        else if (end_t3 && (kind_i == MC_FETCH || kind_i == MC_OPR))
            pc_o <= pc_o + 1'b1;
    end

    // Instruction, read data and store data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_o    <= '0;
            rdata_o <= '0;
            data_o  <= '0;
        end else begin
            if (end_t3 && kind_i == MC_FETCH) ir_o    <= data_i;
            if (end_t3 && kind_i == MC_MRD)   rdata_o <= data_i;
            if (end_td)                       data_o  <= wdata_i;
        end
    end

    // One register per operand byte lane.
    for (genvar g = 0; g < OPR_BYTES; g++) begin : g_lane
        logic [DATA_W-1:0] byte_q;

        // Clear on opcode capture, load on the matching operand cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (end_t3 && kind_i == MC_FETCH)
                byte_q <= '0;
            else if (end_t3 && kind_i == MC_OPR && idx_i == IDX_W'(g))
                byte_q <= data_i;
        end

        assign opr_o[g*DATA_W +: DATA_W] = byte_q;
    end

    // Data access address formed from the operand bytes.
    if (ADDR_W <= OPR_W) begin : g_addr_slice
        assign data_addr = opr_o[ADDR_W-1:0];
    end else begin : g_addr_ext
        assign data_addr = {{(ADDR_W-OPR_W){1'b0}}, opr_o};
    end

    // Bus address: operand address for data cycles, else the PC.
    always_comb begin
        if (kind_i == MC_MRD || kind_i == MC_MWR)
            addr_o = data_addr;
        else
            addr_o = pc_o;
    end

endmodule

// File: rtl/mseq_top.sv
// Module: machine-cycle bus sequencer top. Runs opcode fetch, decode clock,
// operand reads and one optional data read or write per instruction, with
// wait states driven by ready_i. Assumes an external decoder drives
// len_i/acc_i/wdata_i from ir_o during the decode clock.
module mseq_top
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [ADDR_W-1:0]           addr_o,
    input  logic [DATA_W-1:0]           data_i,
    output logic [DATA_W-1:0]           data_o,
    output logic                        rd_o,
    output logic                        wr_o,
    input  logic                        ready_i,
    input  logic [1:0]                  len_i,
    input  logic [1:0]                  acc_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           ir_o,
    output logic [OPR_BYTES*DATA_W-1:0] opr_o,
    output logic [DATA_W-1:0]           rdata_o,
    output logic                        fetch_o,
    output logic                        exec_o
);

    tstate_e           t_w;
    mcyc_e             kind_w;
    logic [IDX_W-1:0]  idx_w;
    logic [ADDR_W-1:0] pc_w;
    logic              strobe_w;

    mseq_tstate u_tstate (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready_i),
        .dec_after_i (kind_w == MC_FETCH),
        .t_o         (t_w)
    );

    mseq_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .t_i    (t_w),
        .len_i  (len_i),
        .acc_i  (acc_i),
        .kind_o (kind_w),
        .idx_o  (idx_w)
    );

    mseq_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .t_i     (t_w),
        .kind_i  (kind_w),
        .idx_i   (idx_w),
        .data_i  (data_i),
        .wdata_i (wdata_i),
        .addr_o  (addr_o),
        .pc_o    (pc_w),
        .ir_o    (ir_o),
        .opr_o   (opr_o),
        .rdata_o (rdata_o),
        .data_o  (data_o)
    );

    // Strobe window spans T2, wait states and T3.
    assign strobe_w = (t_w == TS_T2) || (t_w == TS_TW) || (t_w == TS_T3);

    // Bus strobes and phase indicators.
    always_comb begin
        rd_o    = strobe_w && (kind_w != MC_MWR);
        wr_o    = strobe_w && (kind_w == MC_MWR);
        fetch_o = (kind_w == MC_FETCH) && (t_w != TS_TD);
        exec_o  = (t_w == TS_TD);
    end

endmodule

// File: rtl/mseq_checker.sv
// Module: protocol checker bound to mseq_top. Observes the bus, the T-state
// and the program counter; drives nothing.
module mseq_checker
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready_i,
    input logic              rd_o,
    input logic              wr_o,
    input logic              fetch_o,
    input logic              exec_o,
    input logic [ADDR_W-1:0] addr_o,
    input tstate_e           t_q,
    input logic [ADDR_W-1:0] pc_q
);

    p_no_dual_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o));

    p_t1_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q == TS_T1) |-> (!rd_o && !wr_o));

    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((t_q == TS_T2 || t_q == TS_TW) && !ready_i) |=>
        (t_q == TS_TW && $stable(addr_o) && $stable(rd_o) && $stable(wr_o)));

    p_ready_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((t_q == TS_T2 || t_q == TS_TW) && ready_i) |=> (t_q == TS_T3));

    p_exec_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> !exec_o);

    p_exec_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> (!rd_o && !wr_o));

    p_exec_after_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> $past(fetch_o));

    p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pc_q == $past(pc_q) || pc_q == ADDR_W'($past(pc_q) + 1'b1)));

endmodule

bind mseq_top mseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_i (ready_i),
    .rd_o    (rd_o),
    .wr_o    (wr_o),
    .fetch_o (fetch_o),
    .exec_o  (exec_o),
    .addr_o  (addr_o),
    .t_q     (t_w),
    .pc_q    (pc_w)
);

// File: tb/tb_mseq_top.sv
// Bench: models a 256-byte memory and a decoder (len = ir[1:0],
// access = ir[3:2], store data = ~ir) and walks every machine cycle.
module tb_mseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_o;
    logic [7:0]  data_i, data_o, wdata_i, ir_o, rdata_o;
    logic        rd_o, wr_o, ready_i, fetch_o, exec_o;
    logic [1:0]  len_i, acc_i;
    logic [15:0] opr_o;

    logic [7:0]  mem [256];
    logic [15:0] pc_m;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign data_i  = mem[addr_o[7:0]];
    assign len_i   = ir_o[1:0];
    assign acc_i   = ir_o[3:2];
    assign wdata_i = ~ir_o;

    mseq_top dut (
        .clk(clk), .rst_n(rst_n), .addr_o(addr_o), .data_i(data_i),
        .data_o(data_o), .rd_o(rd_o), .wr_o(wr_o), .ready_i(ready_i),
        .len_i(len_i), .acc_i(acc_i), .wdata_i(wdata_i), .ir_o(ir_o),
        .opr_o(opr_o), .rdata_o(rdata_o), .fetch_o(fetch_o), .exec_o(exec_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick_wait(input int w);
        if (w >= 0) return w;
        if (($urandom % 8) == 0) return 5;
        return int'($urandom % 3);
    endfunction

    // One machine cycle; called at the T1 negedge, returns at the next phase.
    // kind: 0 opcode, 1 operand, 2 data read, 3 data write.
    task automatic mcycle(input int kind, input logic [15:0] a, input int waits,
                          input logic [7:0] wexp, output logic [7:0] got);
        bit exp_rd;
        exp_rd = (kind != 3);
        chk(addr_o == a, "R2", "T1 address", addr_o, a);
        chk(!rd_o && !wr_o, "R2", "T1 strobes", {rd_o, wr_o}, 0);
        chk(fetch_o == (kind == 0), "R6", "fetch flag", fetch_o, kind == 0);
        ready_i = 1'b0;
        @(negedge clk);
        chk(rd_o == exp_rd && wr_o == !exp_rd, "R2", "T2 strobes", {rd_o, wr_o}, {exp_rd, !exp_rd});
        if (kind == 3) chk(data_o == wexp, "R8", "write data", data_o, wexp);
        ready_i = (waits == 0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk(addr_o == a && rd_o == exp_rd && wr_o == !exp_rd, "R3", "wait hold",
                {addr_o, rd_o, wr_o}, {a, exp_rd, !exp_rd});
            if (kind == 3) chk(data_o == wexp, "R3", "wait data hold", data_o, wexp);
            ready_i = (i == waits - 1);
        end
        @(negedge clk);
        chk(addr_o == a && rd_o == exp_rd && wr_o == !exp_rd, "R2", "T3 bus",
            {addr_o, rd_o, wr_o}, {a, exp_rd, !exp_rd});
        got = data_i;
        ready_i = 1'($urandom);
        if (kind == 3) mem[a[7:0]] = data_o;
        @(negedge clk);
    endtask

    // One full instruction at pc_m; called at the T1 negedge of its fetch.
    task automatic run_instr(input int wf, input int wo);
        logic [7:0]  op, b, dummy;
        logic [15:0] opr_m;
        int          nops;
        op = mem[pc_m[7:0]];
        mcycle(0, pc_m, pick_wait(wf), 8'h00, b);
        chk(exec_o == 1'b1 && !rd_o && !wr_o, "R4", "decode clock", {exec_o, rd_o, wr_o}, 3'b100);
        chk(ir_o == op, "R4", "opcode latched", ir_o, op);
        chk(opr_o == 16'h0, "R6", "operands cleared", opr_o, 0);
        pc_m = pc_m + 1'b1;
        nops  = (op[1:0] == 2'd2) ? 1 : (op[1:0] == 2'd3) ? 2 : 0;
        opr_m = 16'h0;
        @(negedge clk);
        chk(exec_o == 1'b0, "R4", "decode one clock", exec_o, 0);
        for (int k = 0; k < nops; k++) begin
            mcycle(1, pc_m, pick_wait(wo), 8'h00, b);
            opr_m[k*8 +: 8] = b;
            pc_m = pc_m + 1'b1;           // R5 checked by the next address
        end
        chk(opr_o == opr_m, "R6", "operand bytes", opr_o, opr_m);
        if (op[3:2] == 2'b01) begin
            mcycle(2, opr_m, pick_wait(wo), 8'h00, b);
            chk(rdata_o == b, "R7", "read data", rdata_o, b);
        end else if (op[3:2] == 2'b10) begin
            mcycle(3, opr_m, pick_wait(wo), ~op, dummy);
        end
        // R9: the caller's next fetch checks address pc_m right here.
    endtask

    initial begin
        void'($urandom(32'd20240611));
        ready_i = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        // Directed program.
        mem[0] = 8'h0B; mem[1] = 8'h40; mem[2] = 8'h12;  // 3 bytes, write @1240
        mem[3] = 8'h06; mem[4] = 8'h40;                  // 2 bytes, read @0040
        mem[5] = 8'h0C;                                  // 1 byte, access code 11
        mem[6] = 8'h01;                                  // 1 byte, no access
        mem[7] = 8'h05;                                  // 1 byte, read @0000
        repeat (3) @(negedge clk);
        chk(addr_o == 16'h0 && fetch_o && !rd_o && !wr_o && !exec_o, "R1", "reset state",
            {addr_o, fetch_o, rd_o, wr_o, exec_o}, {16'h0, 4'b1000});
        rst_n = 1'b1;
        pc_m = 16'h0;
        run_instr(0, 2);   // R8 write, waits on operands and write
        chk(mem[8'h40] == 8'hF4, "R8", "memory written", mem[8'h40], 8'hF4);
        run_instr(5, 0);   // R3 long fetch wait, R7 read-after-write
        chk(rdata_o == 8'hF4, "R7", "read after write", rdata_o, 8'hF4);
        run_instr(1, 0);   // R9 access code 11 ignored
        chk(pc_m == 16'h6, "R9", "pc after no-access", pc_m, 6);
        run_instr(0, 0);
        run_instr(2, 1);   // R7 read at 0000
        chk(rdata_o == 8'h0B, "R7", "read of address 0", rdata_o, 8'h0B);
        for (int n = 0; n < 300; n++) run_instr(-1, -1);
        // R1: reset in mid-run restarts the fetch at 0.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(addr_o == 16'h0 && fetch_o && !rd_o && !wr_o && !exec_o, "R1", "mid-run reset",
            {addr_o, fetch_o, rd_o, wr_o, exec_o}, {16'h0, 4'b1000});
        chk(opr_o == 16'h0 && ir_o == 8'h0, "R1", "registers cleared", {opr_o, ir_o}, 0);
        rst_n = 1'b1;
        pc_m = 16'h0;
        for (int n = 0; n < 20; n++) run_instr(-1, -1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule